// File: doc/BRIEF.md
# Windowed Framebuffer Write Addresser

This block sits between a serial-peripheral front end and a packed framebuffer RAM that holds 4-bit pixels, two to a byte. Each incoming display byte goes to the RAM at the current cursor. The cursor then moves to the next cell inside a rectangular window. A command decoder sets the window's column and row bounds. The RAM is 64 byte-columns wide and 80 rows tall. A byte's address is its column plus 64 times its row.

The cursor can advance in two orders, picked by a mode input. In horizontal order it runs along the row first. In vertical order it runs down the column first. Each axis wraps back to its own start value independently of the other. Every written byte also raises a redraw flag, which the scanout side clears once it has refreshed the panel.

Top module: `wfb_wr_addresser`

## Requirements
- R1: When `byte_valid_i` is high, in the same cycle `wr_en_o` is high, `wr_data_o` equals `byte_data_i`, and `wr_addr_o` equals column + 64*row of the current cursor. Addresses span 0..5119.
- R2: After reset the cursor is at column 0, row 0. The column window is 0..63, the row window is 0..79, and `redraw_o` is low.
- R3: With `vertical_i` = 0, each byte moves the column up by one. A byte written at or past the end column sends the column back to the start column and moves the row on. A row move from at or past the end row returns the row to the start row.
- R4: With `vertical_i` = 1, each byte moves the row up by one. A byte written at or past the end row sends the row back to the start row and moves the column on. A column move from at or past the end column returns the column to the start column.
- R5: If a start value lies above its end value, the cursor on that axis stays at the start value, and every byte on that axis counts as a wrap.
- R6: A load strobe (`col_load_i` or `row_load_i`) stores the start and end values. It also places the cursor on that axis at the new start, effective from the next cycle. A byte in the same cycle as a load is written at the old address, and the load's cursor value wins over that byte's advance.
- R7: Row start and end values of 80..127 are reduced modulo 80 on load. Column values are 6 bits and are used as given.
- R8: Each byte sets `redraw_o` from the next cycle. `clear_redraw_i` clears it from the next cycle. When both happen in the same cycle, the flag ends up set.
- R9: With no byte and no load, the cursor does not move. Changing `vertical_i` alone leaves `wr_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Display byte strobe |
| byte_data_i | input | 8 | Display byte (two pixels) |
| col_load_i | input | 1 | Load column window |
| col_start_i | input | 6 | Column window start |
| col_end_i | input | 6 | Column window end |
| row_load_i | input | 1 | Load row window |
| row_start_i | input | 7 | Row window start |
| row_end_i | input | 7 | Row window end |
| vertical_i | input | 1 | 1: row-first order, 0: column-first order |
| clear_redraw_i | input | 1 | Scanout acknowledges redraw |
| wr_en_o | output | 1 | RAM write enable |
| wr_addr_o | output | 13 | RAM byte address |
| wr_data_o | output | 8 | RAM write data |
| redraw_o | output | 1 | Redraw pending |

## Verification
The hardest conditions to reach are a double wrap, where both axes return to their starts on the same byte, and a load that lands in the same cycle as a byte. The stimulus reaches the double wrap with small windows: a 3x2 window in both orders, and a 2x2 window at the far corner of the RAM (address 5119 back to the window origin). It reaches the load collision by raising a column load and a byte strobe together. The bench then compares the address used for that byte against the old cursor, and the next address against the new start. A window whose start is above its end, and row loads of 80 and above, round out the bound handling.

// File: rtl/wfb_pkg.sv
package wfb_pkg;
  localparam int COLS   = 64;
  localparam int ROWS   = 80;
  localparam int DATA_W = 8;
  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int ADDR_W = $clog2(COLS * ROWS);
endpackage

// File: rtl/wfb_axis_ctr.sv
// One cursor axis: windowed position with wrap to start.
module wfb_axis_ctr #(
  parameter int W     = 6,
  parameter int LIMIT = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  input  logic         step_i,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] end_o,
  output logic         at_end_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] start_r, end_r;
  logic [W-1:0] pos_q, start_q, end_q;

  generate
    if (LIMIT == (1 << W)) begin : g_pow2
      assign start_r = start_i;
      assign end_r   = end_i;
    end else begin : g_mod
      // single subtract: valid while 2*LIMIT >= 2**W
      localparam logic [W-1:0] LIM = W'(LIMIT);
      assign start_r = (start_i >= LIM) ? start_i - LIM : start_i;
      assign end_r   = (end_i   >= LIM) ? end_i   - LIM : end_i;
    end
  endgenerate

  assign at_end_o = (pos_q >= end_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      start_q <= '0;
      end_q   <= LAST;
    end else if (load_i) begin
      pos_q   <= start_r;
      start_q <= start_r;
      end_q   <= end_r;
    end else if (step_i) begin
      pos_q <= at_end_o ? start_q : pos_q + 1'b1;
    end
  end

  assign pos_o = pos_q;
  assign end_o = end_q;
endmodule

// File: rtl/wfb_redraw_flag.sv
module wfb_redraw_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/wfb_wr_addresser.sv
module wfb_wr_addresser
  import wfb_pkg::*;
#(
  parameter int NCOL = COLS,
  parameter int NROW = ROWS,
  parameter int DW   = DATA_W,
  localparam int CW  = $clog2(NCOL),
  localparam int RW  = $clog2(NROW),
  localparam int AW  = $clog2(NCOL * NROW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_data_i,
  input  logic          col_load_i,
  input  logic [CW-1:0] col_start_i,
  input  logic [CW-1:0] col_end_i,
  input  logic          row_load_i,
  input  logic [RW-1:0] row_start_i,
  input  logic [RW-1:0] row_end_i,
  input  logic          vertical_i,
  input  logic          clear_redraw_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          redraw_o
);
  logic [CW-1:0] col_q, col_end_q;
  logic [RW-1:0] row_q, row_end_q;
  logic          col_at_end, row_at_end;
  logic          col_step, row_step;

  // leading axis steps every byte; trailing axis only when the leader wraps
  assign col_step = byte_valid_i & (~vertical_i | row_at_end);
  assign row_step = byte_valid_i & ( vertical_i | col_at_end);

  wfb_axis_ctr #(.W(CW), .LIMIT(NCOL)) u_col (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (col_load_i),
    .start_i  (col_start_i),
    .end_i    (col_end_i),
    .step_i   (col_step),
    .pos_o    (col_q),
    .end_o    (col_end_q),
    .at_end_o (col_at_end)
  );

  wfb_axis_ctr #(.W(RW), .LIMIT(NROW)) u_row (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (row_load_i),
    .start_i  (row_start_i),
    .end_i    (row_end_i),
    .step_i   (row_step),
    .pos_o    (row_q),
    .end_o    (row_end_q),
    .at_end_o (row_at_end)
  );

  wfb_redraw_flag u_redraw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (byte_valid_i),
    .clr_i  (clear_redraw_i),
    .flag_o (redraw_o)
  );

  assign wr_en_o   = byte_valid_i;
  assign wr_data_o = byte_data_i;
  assign wr_addr_o = AW'(row_q) * AW'(NCOL) + AW'(col_q);
endmodule

// File: rtl/wfb_wr_addr_chk.sv
module wfb_wr_addr_chk #(
  parameter int NCOL = 64,
  parameter int NROW = 80,
  parameter int CW   = 6,
  parameter int RW   = 7,
  parameter int AW   = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          byte_valid_i,
  input logic          col_load_i,
  input logic [CW-1:0] col_start_i,
  input logic          row_load_i,
  input logic          vertical_i,
  input logic          clear_redraw_i,
  input logic [AW-1:0] wr_addr_o,
  input logic          redraw_o,
  input logic [CW-1:0] col_q,
  input logic [CW-1:0] col_end_q,
  input logic [RW-1:0] row_q,
  input logic [RW-1:0] row_end_q
);
  logic idle;
  assign idle = !byte_valid_i && !col_load_i && !row_load_i;

  a_r1_addr_in_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_addr_o) < NCOL * NROW);

  a_r8_redraw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |=> redraw_o);

  a_r8_redraw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_redraw_i && !byte_valid_i) |=> !redraw_o);

  a_r6_col_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_load_i && !row_load_i) |=> int'(wr_addr_o) % NCOL == int'($past(col_start_i)));

  a_r3_horiz_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !vertical_i && !col_load_i && !row_load_i && col_q < col_end_q)
    |=> wr_addr_o == AW'($past(wr_addr_o) + 1'b1));

  a_r4_vert_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && vertical_i && !col_load_i && !row_load_i && row_q < row_end_q)
    |=> wr_addr_o == AW'($past(wr_addr_o) + AW'(NCOL)));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(wr_addr_o));
endmodule

bind wfb_wr_addresser wfb_wr_addr_chk #(
  .NCOL(NCOL), .NROW(NROW), .CW(CW), .RW(RW), .AW(AW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .byte_valid_i   (byte_valid_i),
  .col_load_i     (col_load_i),
  .col_start_i    (col_start_i),
  .row_load_i     (row_load_i),
  .vertical_i     (vertical_i),
  .clear_redraw_i (clear_redraw_i),
  .wr_addr_o      (wr_addr_o),
  .redraw_o       (redraw_o),
  .col_q          (col_q),
  .col_end_q      (col_end_q),
  .row_q          (row_q),
  .row_end_q      (row_end_q)
);

// File: tb/tb_wfb_wr_addresser.sv
`timescale 1ns/1ps
module tb_wfb_wr_addresser;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        col_load_i = 1'b0;
  logic [5:0]  col_start_i = '0;
  logic [5:0]  col_end_i = '0;
  logic        row_load_i = 1'b0;
  logic [6:0]  row_start_i = '0;
  logic [6:0]  row_end_i = '0;
  logic        vertical_i = 1'b0;
  logic        clear_redraw_i = 1'b0;
  logic        wr_en_o;
  logic [12:0] wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        redraw_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  // bench model of the cursor, from the requirements
  int m_col, m_row, m_cs, m_ce, m_rs, m_re;
  bit m_vert;

  always #5 clk = ~clk;

  wfb_wr_addresser dut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .col_load_i(col_load_i), .col_start_i(col_start_i), .col_end_i(col_end_i),
    .row_load_i(row_load_i), .row_start_i(row_start_i), .row_end_i(row_end_i),
    .vertical_i(vertical_i), .clear_redraw_i(clear_redraw_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .redraw_o(redraw_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr();
    return m_col + 64 * m_row;
  endfunction

  function automatic void model_step();
    if (!m_vert) begin
      if (m_col >= m_ce) begin
        m_col = m_cs;
        m_row = (m_row >= m_re) ? m_rs : m_row + 1;
      end else m_col++;
    end else begin
      if (m_row >= m_re) begin
        m_row = m_rs;
        m_col = (m_col >= m_ce) ? m_cs : m_col + 1;
      end else m_row++;
    end
  endfunction

  // all tasks start and end just after a falling edge
  task automatic send_byte(input logic [7:0] d, input string req);
    byte_valid_i = 1'b1;
    byte_data_i  = d;
    #1;
    chk(wr_en_o === 1'b1 && wr_data_o === d, "R1", int'(wr_data_o), int'(d));
    chk(int'(wr_addr_o) == exp_addr(), req, int'(wr_addr_o), exp_addr());
    @(negedge clk);
    byte_valid_i = 1'b0;
    model_step();
  endtask

  task automatic load_col(input int s, input int e);
    col_load_i = 1'b1; col_start_i = 6'(s); col_end_i = 6'(e);
    @(negedge clk);
    col_load_i = 1'b0;
    m_cs = s; m_ce = e; m_col = s;
  endtask

  task automatic load_row(input int s, input int e);
    row_load_i = 1'b1; row_start_i = 7'(s); row_end_i = 7'(e);
    @(negedge clk);
    row_load_i = 1'b0;
    m_rs = s % 80; m_re = e % 80; m_row = s % 80;
  endtask

  task automatic set_mode(input bit v);
    vertical_i = v; m_vert = v;
  endtask

  task automatic t_reset();
    #1;
    chk(wr_addr_o == 0, "R2", int'(wr_addr_o), 0);
    chk(redraw_o == 1'b0, "R2", int'(redraw_o), 0);
    chk(wr_en_o == 1'b0, "R1", int'(wr_en_o), 0);
    // full default window: row 0 fills 0..63 then row 1 starts at 64
    for (int i = 0; i < 65; i++) send_byte(8'(i), "R2");
    chk(int'(wr_addr_o) == 65, "R2", int'(wr_addr_o), 65);
  endtask

  task automatic t_horiz();
    set_mode(1'b0);
    load_col(2, 4);
    load_row(3, 4);
    for (int i = 0; i < 7; i++) send_byte(8'hA0 + 8'(i), "R3");
    chk(int'(wr_addr_o) == 3 + 64 * 3, "R3", int'(wr_addr_o), 3 + 64 * 3);
  endtask

  task automatic t_vert();
    set_mode(1'b1);
    load_col(2, 4);
    load_row(3, 4);
    for (int i = 0; i < 7; i++) send_byte(8'hB0 + 8'(i), "R4");
    chk(int'(wr_addr_o) == 2 + 64 * 4, "R4", int'(wr_addr_o), 2 + 64 * 4);
  endtask

  task automatic t_corner();
    set_mode(1'b0);
    load_col(62, 63);
    load_row(78, 79);
    for (int i = 0; i < 5; i++) send_byte(8'h11, "R1");
    chk(int'(wr_addr_o) == 63 + 64 * 78, "R1", int'(wr_addr_o), 63 + 64 * 78);
  endtask

  task automatic t_inverted();
    set_mode(1'b0);
    load_col(10, 5);
    load_row(0, 1);
    for (int i = 0; i < 3; i++) send_byte(8'h22, "R5");
    chk(int'(wr_addr_o) == 10 + 64, "R5", int'(wr_addr_o), 10 + 64);
  endtask

  task automatic t_row_mod();
    set_mode(1'b1);
    load_col(0, 1);
    load_row(85, 87);
    chk(int'(wr_addr_o) == 5 * 64, "R7", int'(wr_addr_o), 5 * 64);
    for (int i = 0; i < 4; i++) send_byte(8'h33, "R7");
    load_row(127, 79);
    chk(int'(wr_addr_o) == 1 + 47 * 64, "R7", int'(wr_addr_o), 1 + 47 * 64);
  endtask

  task automatic t_load_collide();
    int old;
    set_mode(1'b0);
    load_col(0, 63);
    load_row(2, 9);
    old = exp_addr();
    col_load_i = 1'b1; col_start_i = 6'd20; col_end_i = 6'd30;
    byte_valid_i = 1'b1; byte_data_i = 8'h5A;
    #1;
    chk(int'(wr_addr_o) == old, "R6", int'(wr_addr_o), old);
    @(negedge clk);
    col_load_i = 1'b0; byte_valid_i = 1'b0;
    m_cs = 20; m_ce = 30; m_col = 20;
    #1;
    chk(int'(wr_addr_o) == 20 + 2 * 64, "R6", int'(wr_addr_o), 20 + 2 * 64);
    @(negedge clk);
  endtask

  task automatic t_redraw();
    clear_redraw_i = 1'b1;
    @(negedge clk);
    clear_redraw_i = 1'b0;
    chk(redraw_o == 1'b0, "R8", int'(redraw_o), 0);
    send_byte(8'h44, "R8");
    chk(redraw_o == 1'b1, "R8", int'(redraw_o), 1);
    clear_redraw_i = 1'b1;
    send_byte(8'h45, "R8");
    clear_redraw_i = 1'b0;
    chk(redraw_o == 1'b1, "R8", int'(redraw_o), 1);
  endtask

  task automatic t_idle();
    int a;
    a = exp_addr();
    set_mode(1'b1);
    @(negedge clk);
    set_mode(1'b0);
    repeat (3) @(negedge clk);
    chk(int'(wr_addr_o) == a, "R9", int'(wr_addr_o), a);
    chk(wr_en_o == 1'b0, "R9", int'(wr_en_o), 0);
  endtask

  initial begin
    m_col = 0; m_row = 0; m_cs = 0; m_ce = 63; m_rs = 0; m_re = 79; m_vert = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_horiz();
    t_vert();
    t_corner();
    t_inverted();
    t_row_mod();
    t_load_collide();
    t_redraw();
    t_idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule